// File: doc/BRIEF.md
# Iterative Radix-4 Booth Multiply-Accumulate Unit

This block multiplies two 32-bit operands over several clock cycles, retiring eight multiplier bits in each busy cycle. Every cycle the multiplier window is recoded into four radix-4 Booth digits. Four chained carry-save layers fold the four resulting partial products into a running sum/carry pair, which stays in redundant form from one cycle to the next. When the multiplier bits that have not been consumed are nothing but sign extension, the loop stops early. After at most four passes, one carry-propagate addition in a separate cycle resolves the pair into the result.

A caller pulses `start_i` while the unit is idle. It selects signed or unsigned operands, a 64-bit or 32-bit result, and whether an addend is accumulated. The addend seeds the running sum when the operation is accepted, so accumulation costs no cycle. `busy_o` covers the whole operation. `done_o` marks the single cycle in which a fresh `result_o` first appears, and `result_o` holds that value until the next completion.

Top module: `booth_mac_iter`

## Requirements
- R1: With `long_i`=1 and `acc_en_i`=0, `result_o` equals the full 64-bit product of `mcand_i` and `mplier_i`. Both operands are two's complement when `signed_i`=1 and unsigned when `signed_i`=0.
- R2: With `acc_en_i`=1 and `long_i`=1, `result_o` equals the product plus `acc_i`, modulo 2^64.
- R3: With `long_i`=0, `result_o[31:0]` equals the low 32 bits of the product plus (when `acc_en_i`=1) `acc_i[31:0]`. `result_o[63:32]` is zero, and `acc_i[63:32]` has no effect.
- R4: The number of iterations N is the smallest value from 1 to 4 for which multiplier bits 31 down to 8N-1 all equal the fill bit. The fill bit is bit 31 in signed mode and 0 in unsigned mode. N is 4 when no smaller value qualifies. `done_o` rises N+1 cycles after the clock edge that accepted `start_i`.
- R5: In unsigned mode, a multiplier with bit 31 set takes four iterations and still produces the correct unsigned product.
- R6: `done_o` is high for exactly one cycle per operation. `busy_o` is high from the accepting edge until the edge that raises `done_o`.
- R7: `start_i` and all operand inputs are ignored while `busy_o` is high. Changing them during an operation alters neither its result nor its timing, and starts no second operation.
- R8: After reset, `busy_o`=0, `done_o`=0 and `result_o`=0.
- R9: Enabling accumulation does not change the cycle count of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| long_i | input | 1 | 1: 64-bit result, 0: 32-bit result |
| acc_en_i | input | 1 | Add `acc_i` to the product |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier |
| acc_i | input | 64 | Accumulate addend |
| result_o | output | 64 | Result, held until the next completion |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that `start_i` and the mode inputs are known at every clock edge after reset, and that the only request accepted is one made while the unit is idle. The stimulus drives every input on the falling edge and keeps every signal at a defined value from time zero. In the one test that holds `start_i` high while the unit is busy, the request is dropped before completion, so the assertions see no back-to-back acceptance. Multiplier values sit on each early-termination boundary: bit 8N-1 is flipped against the fill, so both adjacent iteration counts are observed.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIN  = 2'd2
  } mac_state_e;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_dig_t;

  // Window bits {high, mid, low} -> digit in {-2,-1,0,+1,+2}
  function automatic booth_dig_t booth_recode(input logic [2:0] w);
    booth_dig_t d;
    d.one = w[1] ^ w[0];
    d.two = (w == 3'b011) || (w == 3'b100);
    d.neg = w[2] && !(w[1] && w[0]);
    return d;
  endfunction

endpackage

// File: rtl/booth_layer.sv
module booth_layer #(
  parameter int W = 64
) (
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] x_i,
  input  logic [2:0]   win_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  import booth_mac_pkg::*;

  booth_dig_t     dig;
  logic [W-1:0]   mag;
  logic [W-1:0]   pp;
  logic [W-1:0]   maj;

  always_comb begin
    dig = booth_recode(win_i);
    if (dig.two)      mag = {x_i[W-2:0], 1'b0};
    else if (dig.one) mag = x_i;
    else              mag = '0;
    pp  = dig.neg ? ~mag : mag;
    // 3:2 compression; the +1 of a negated digit rides in the freed carry LSB
    s_o = s_i ^ c_i ^ pp;
    maj = (s_i & c_i) | (s_i & pp) | (c_i & pp);
    c_o = {maj[W-2:0], dig.neg};
  end

endmodule

// File: rtl/booth_mac_iter.sv
module booth_mac_iter #(
  parameter int XW     = 32,
  parameter int LAYERS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            signed_i,
  input  logic            long_i,
  input  logic            acc_en_i,
  input  logic [XW-1:0]   mcand_i,
  input  logic [XW-1:0]   mplier_i,
  input  logic [2*XW-1:0] acc_i,
  output logic [2*XW-1:0] result_o,
  output logic            busy_o,
  output logic            done_o
);
  import booth_mac_pkg::*;

  localparam int RW    = 2 * XW;
  localparam int STEP  = 2 * LAYERS;
  localparam int ITERS = XW / STEP;
  localparam int ITW   = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [ITW-1:0] IT_LAST = ITW'(ITERS - 1);

  mac_state_e    st_q, st_d;
  logic [ITW-1:0] it_q, it_d;
  logic [RW-1:0] s_q, s_d, c_q, c_d, x_q, x_d, res_q, res_d;
  logic [XW-1:0] m_q, m_d;
  logic          prev_q, prev_d, fill_q, fill_d, long_q, long_d, done_q, done_d;

  logic [RW-1:0] s_ch [LAYERS+1];
  logic [RW-1:0] c_ch [LAYERS+1];
  logic [RW-1:0] sum;
  logic          rest_fill, last;

  assign s_ch[0] = s_q;
  assign c_ch[0] = c_q;

  for (genvar k = 0; k < LAYERS; k++) begin : g_layer
    logic [2:0] win;
    if (k == 0) begin : g_lo
      assign win = {m_q[1], m_q[0], prev_q};
    end else begin : g_hi
      assign win = m_q[2*k+1 : 2*k-1];
    end
    booth_layer #(.W(RW)) u_layer (
      .s_i  (s_ch[k]),
      .c_i  (c_ch[k]),
      .x_i  (x_q << (2*k)),
      .win_i(win),
      .s_o  (s_ch[k+1]),
      .c_o  (c_ch[k+1])
    );
  end

  // Unconsumed multiplier bits plus the last consumed bit all equal the fill
  assign rest_fill = fill_q ? (&m_q[XW-1:STEP-1]) : ~(|m_q[XW-1:STEP-1]);
  assign last      = rest_fill || (it_q == IT_LAST);
  assign sum       = s_q + c_q;

  always_comb begin
    st_d   = st_q;
    it_d   = it_q;
    s_d    = s_q;
    c_d    = c_q;
    x_d    = x_q;
    m_d    = m_q;
    prev_d = prev_q;
    fill_d = fill_q;
    long_d = long_q;
    res_d  = res_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_ITER;
          it_d   = '0;
          x_d    = signed_i ? {{XW{mcand_i[XW-1]}}, mcand_i} : {{XW{1'b0}}, mcand_i};
          m_d    = mplier_i;
          prev_d = 1'b0;
          fill_d = signed_i & mplier_i[XW-1];
          long_d = long_i;
          if (!acc_en_i)   s_d = '0;
          else if (long_i) s_d = acc_i;
          else             s_d = {{XW{1'b0}}, acc_i[XW-1:0]};
          // unsigned multiplier with top bit set: add the missing 2^XW * mcand
          c_d    = (!signed_i && mplier_i[XW-1]) ? {mcand_i, {XW{1'b0}}} : '0;
        end
      end
      ST_ITER: begin
        s_d    = s_ch[LAYERS];
        c_d    = c_ch[LAYERS];
        x_d    = x_q << STEP;
        m_d    = {{STEP{fill_q}}, m_q[XW-1:STEP]};
        prev_d = m_q[STEP-1];
        it_d   = it_q + 1'b1;
        if (last) st_d = ST_FIN;
      end
      ST_FIN: begin
        res_d  = long_q ? sum : {{XW{1'b0}}, sum[XW-1:0]};
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      it_q   <= '0;
      s_q    <= '0;
      c_q    <= '0;
      x_q    <= '0;
      m_q    <= '0;
      prev_q <= 1'b0;
      fill_q <= 1'b0;
      long_q <= 1'b0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      it_q   <= it_d;
      s_q    <= s_d;
      c_q    <= c_d;
      x_q    <= x_d;
      m_q    <= m_d;
      prev_q <= prev_d;
      fill_q <= fill_d;
      long_q <= long_d;
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  assign result_o = res_q;
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o) && !busy_o);

  // R4
  iter_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ITER && it_q == IT_LAST) |=> st_q == ST_FIN);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!busy_o || ($stable(long_q) && $stable(fill_q))));

  // R3
  short_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !long_q) |-> result_o[RW-1:XW] == '0);

endmodule

// File: tb/booth_mac_iter_test.sv
module booth_mac_iter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, signed_i = 1'b0, long_i = 1'b0, acc_en_i = 1'b0;
  logic [31:0] mcand_i = '0, mplier_i = '0;
  logic [63:0] acc_i = '0;
  logic [63:0] result_o;
  logic        busy_o, done_o;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  booth_mac_iter uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .long_i(long_i), .acc_en_i(acc_en_i), .mcand_i(mcand_i),
    .mplier_i(mplier_i), .acc_i(acc_i), .result_o(result_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // {signed, long, acc_en, mcand, mplier, acc}
  localparam logic [130:0] VEC [15] = '{
    {3'b110, 32'd5,        32'd7,        64'd0},                  // R1 N=1
    {3'b110, 32'hFFFFFFFD, 32'd100,      64'd0},                  // R1 negative mcand
    {3'b110, 32'h12345678, 32'hFFFFFFFE, 64'd0},                  // R1 negative mplier N=1
    {3'b110, 32'h0000ABCD, 32'h00001234, 64'd0},                  // R4 N=2
    {3'b110, 32'hFFFF0001, 32'h00400000, 64'd0},                  // R4 N=3
    {3'b110, 32'h7FFFFFFF, 32'h7FFFFFFF, 64'd0},                  // R4 N=4
    {3'b110, 32'h80000000, 32'h80000000, 64'd0},                  // R1 most negative
    {3'b010, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'd0},                  // R5
    {3'b010, 32'h00000003, 32'h00000080, 64'd0},                  // R4 unsigned boundary N=2
    {3'b110, 32'h00000009, 32'hFFFFFF80, 64'd0},                  // R4 boundary N=1
    {3'b110, 32'h00000009, 32'hFFFFFF7F, 64'd0},                  // R4 boundary N=2
    {3'b111, 32'hFFFFFFFB, 32'd6,        64'h0000000100000000},   // R2
    {3'b101, 32'd3,        32'd4,        64'hDEADBEEF00000010},   // R3 upper acc ignored
    {3'b000, 32'hABCDEF01, 32'h80000000, 64'd0},                  // R5 short
    {3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'hFFFFFFFFFFFFFFFF}    // R2 unsigned wrap
  };

  function automatic logic [63:0] ref_res(input logic sg, lg, ae,
      input logic [31:0] a, b, input logic [63:0] acc);
    logic [63:0] ae64, be64, p;
    ae64 = sg ? {{32{a[31]}}, a} : {32'd0, a};
    be64 = sg ? {{32{b[31]}}, b} : {32'd0, b};
    p = ae64 * be64 + (ae ? acc : 64'd0);
    return lg ? p : {32'd0, p[31:0]};
  endfunction

  function automatic int ref_iters(input logic sg, input logic [31:0] b);
    logic f;
    logic ok;
    f = sg & b[31];
    for (int n = 1; n < 4; n++) begin
      ok = 1'b1;
      for (int i = 8*n-1; i < 32; i++) if (b[i] != f) ok = 1'b0;
      if (ok) return n;
    end
    return 4;
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drives one operation; returns edges counted from the accepting edge to done
  task automatic run_op(input logic sg, lg, ae, input logic [31:0] a, b,
      input logic [63:0] acc, output int cyc, output logic [63:0] res);
    @(negedge clk);
    signed_i = sg; long_i = lg; acc_en_i = ae;
    mcand_i = a; mplier_i = b; acc_i = acc; start_i = 1'b1;
    cyc = 0;
    while (cyc < 20) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start_i = 1'b0;
      if (cyc == 1) check64("R6 busy after accept", {63'd0, busy_o}, 64'd1);
      if (done_o) break;
    end
    res = result_o;
    @(negedge clk);
    check64("R6 done width", {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    #3_000_000;
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    int cyc, cyc2;
    logic [63:0] res, res2;
    repeat (3) @(negedge clk);
    // R8
    check64("R8 busy", {63'd0, busy_o}, 64'd0);
    check64("R8 done", {63'd0, done_o}, 64'd0);
    check64("R8 result", result_o, 64'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 15; v++) begin
      logic sg, lg, ae;
      logic [31:0] a, b;
      logic [63:0] acc;
      string tg;
      {sg, lg, ae, a, b, acc} = VEC[v];
      if (!sg && b[31]) tg = "R5";
      else if (!lg)     tg = "R3";
      else if (ae)      tg = "R2";
      else              tg = "R1";
      run_op(sg, lg, ae, a, b, acc, cyc, res);
      check64(tg, res, ref_res(sg, lg, ae, a, b, acc));
      check64("R4 latency", 64'(cyc), 64'(ref_iters(sg, b) + 2));
    end

    // R9: same operands with and without accumulation
    run_op(1'b1, 1'b1, 1'b0, 32'h00001111, 32'h00022222, 64'd0, cyc, res);
    run_op(1'b1, 1'b1, 1'b1, 32'h00001111, 32'h00022222, 64'h55, cyc2, res2);
    check64("R9 latency", 64'(cyc2), 64'(cyc));
    check64("R9 sum", res2, res + 64'h55);

    // R7: start and operands change mid-operation
    @(negedge clk);
    signed_i = 1'b1; long_i = 1'b1; acc_en_i = 1'b0;
    mcand_i = 32'h7FFFFFFF; mplier_i = 32'h7FFFFFFF; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    signed_i = 1'b0; long_i = 1'b0; acc_en_i = 1'b1; acc_i = 64'hFFFF;
    mcand_i = 32'd1; mplier_i = 32'd1;
    cyc = 1;
    @(posedge clk); cyc++;
    @(negedge clk); start_i = 1'b0;
    while (!done_o && cyc < 20) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    check64("R7 result", result_o, ref_res(1'b1, 1'b1, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 64'd0));
    check64("R7 latency", 64'(cyc), 64'd6);
    cyc2 = 0;
    repeat (4) begin
      @(negedge clk);
      if (done_o || busy_o) cyc2++;
    end
    check64("R7 no second op", 64'(cyc2), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule